// File: doc/BRIEF.md
# Serial Management Frame Responder

This block is the device side of a software-driven two-wire management link. The host never drives the link pins directly. Instead it writes a small control word that holds a clock level, a data level and a drive-enable flag. The responder watches the clock bit. On every low-to-high change it shifts one sampled bit into a sliding window. When it finds a run of ones long enough to synchronise, it decodes the next sixteen bits as a frame header: start pattern, operation, device address, register address and turnaround.

An accepted read fetches one of thirty-two sixteen-bit registers. The value then comes back MSB first on the control word's data-return bit, one bit per clock rise. An accepted write is reported on a one-cycle commit strobe that carries both addresses and the data word. The write has no effect on the register bank. The bank resets to all zeros, except two identifier registers.

Top module: `mgmt_frame_responder`

## Requirements
- R1: A bit is sampled only on a control write whose clock bit (bit 3) is 1 while the previously written clock bit was 0. Writes that do not create such a rise change neither the window nor the returned data bit.
- R2: The sampled bit is the data bit (bit 0) ANDed with the drive-enable bit (bit 2). With drive-enable low, a high data level samples as 0.
- R3: When the window holds WIDTH consecutive sampled ones (32 by default), the bit counter is reloaded. The sixteenth sampled bit after that is taken as the last header bit.
- R4: The header is decoded from the sixteen most recent bits: start [15:14], operation [13:12], device address [11:7], register address [6:2], turnaround [1:0].
- R5: A write is accepted only when start=01, operation=01 and turnaround=10. On the sixteenth data bit after the header, commit_vld pulses for one cycle with the addresses and the sixteen data bits, first bit as MSB.
- R6: A read is accepted when start=01, operation=10 and turnaround bit 0 is 0. The addressed register is shifted out MSB first on bit 1 of ctl_rdata, one bit per each of the sixteen following rises.
- R7: Any other header returns the responder to idle. No data is returned and no commit is produced.
- R8: Reset clears the control word and all registers, except register 2 = 0x0022 and register 3 = 0x161A.
- R9: Accepted writes leave the register bank unchanged, so a later read returns the reset value.
- R10: ctl_rdata holds clock in bit 3, drive-enable in bit 2, returned data in bit 1 and data in bit 0. Bit 1 is owned by the responder, and host writes to it are ignored.
- R11: The counter decrements on every rise and stops at -1 once it expires. A run of WIDTH-1 ones after a zero does not re-arm it, so the header that follows is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 4 | Control word write value |
| ctl_rdata | output | 4 | Control word read value including returned data |
| commit_vld | output | 1 | One-cycle pulse on an accepted write |
| commit_phy | output | 5 | Device address of the committed write |
| commit_reg | output | 5 | Register address of the committed write |
| commit_data | output | 16 | Data word of the committed write |

## Verification
The bench uses the default parameters: a 32-bit synchronising window and the identifier values 0x0022 and 0x161A at registers 2 and 3. With these, a single stimulus table can cover reads of the identifier and zero registers at both address extremes, and write commits followed by read-backs. Directed frames probe the one-short preamble, an over-long preamble, a turnaround with bit 0 set, invalid start and operation codes, and gating by the drive-enable bit. A host write made in mid-read checks that the returned bit is held.

// File: rtl/mgmt_resp_pkg.sv
package mgmt_resp_pkg;

  // control word bit positions (host-visible layout)
  localparam int CB_DO  = 0;
  localparam int CB_DI  = 1;
  localparam int CB_OE  = 2;
  localparam int CB_CLK = 3;
  localparam int CTL_W  = 4;

  // header geometry
  localparam int HDR_W  = 16;
  localparam int HDR_AW = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } xact_e;

  function automatic logic sample_bit(input logic d, input logic oe);
    return d & oe;
  endfunction

  function automatic xact_e decode_hdr(input logic [HDR_W-1:0] h);
    logic [1:0] st;
    logic [1:0] op;
    logic [1:0] ta;
    st = h[15:14];
    op = h[13:12];
    ta = h[1:0];
    if (st == 2'b01 && op == 2'b01 && ta == 2'b10) return ST_WR;
    if (st == 2'b01 && op == 2'b10 && !ta[0])      return ST_RD;
    return ST_IDLE;
  endfunction

  function automatic logic [HDR_AW-1:0] phy_of(input logic [HDR_W-1:0] h);
    return h[11:7];
  endfunction

  function automatic logic [HDR_AW-1:0] reg_of(input logic [HDR_W-1:0] h);
    return h[6:2];
  endfunction

endpackage

// File: rtl/mgmt_ctl_port.sv
module mgmt_ctl_port
  import mgmt_resp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CTL_W-1:0] wdata,
  input  logic             di,
  output logic [CTL_W-1:0] rdata,
  output logic             rise,
  output logic             samp
);
  logic do_q, oe_q, clk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      do_q  <= 1'b0;
      oe_q  <= 1'b0;
      clk_q <= 1'b0;
    end else if (we) begin
      do_q  <= wdata[CB_DO];
      oe_q  <= wdata[CB_OE];
      clk_q <= wdata[CB_CLK];
    end
  end

  // the host's write of bit CB_DI is dropped: that bit is responder-owned
  always_comb begin
    rise = we && wdata[CB_CLK] && !clk_q;
    samp = sample_bit(wdata[CB_DO], wdata[CB_OE]);
    rdata = '0;
    rdata[CB_DO]  = do_q;
    rdata[CB_DI]  = di;
    rdata[CB_OE]  = oe_q;
    rdata[CB_CLK] = clk_q;
  end
endmodule

// File: rtl/mgmt_reg_bank.sv
module mgmt_reg_bank #(
  parameter int          NREG    = 32,
  parameter int          DW      = 16,
  parameter int          AW      = $clog2(NREG),
  parameter int          IDA_IDX = 2,
  parameter logic [15:0] IDA_VAL = 16'h0022,
  parameter int          IDB_IDX = 3,
  parameter logic [15:0] IDB_VAL = 16'h161A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  function automatic logic [DW-1:0] init_val(input int i);
    if (i == IDA_IDX) return DW'(IDA_VAL);
    if (i == IDB_IDX) return DW'(IDB_VAL);
    return '0;
  endfunction

  logic [DW-1:0] mem [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rst_n) mem[g] <= init_val(g);
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/mgmt_frame_engine.sv
module mgmt_frame_engine
  import mgmt_resp_pkg::*;
#(
  parameter int WIN = 32,
  parameter int DW  = HDR_W,
  parameter int AW  = HDR_AW,
  parameter int CW  = $clog2(WIN + 1) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rise,
  input  logic                 samp,
  output logic [AW-1:0]        bank_addr,
  input  logic [DW-1:0]        bank_data,
  output logic                 di,
  output logic                 commit_vld,
  output logic [AW-1:0]        commit_phy,
  output logic [AW-1:0]        commit_reg,
  output logic [DW-1:0]        commit_data,
  output logic                 sync_hit,
  output logic signed [CW-1:0] cnt_o,
  output xact_e                st_o
);
  localparam int HDR = HDR_W;

  logic [WIN-1:0]        shift_q, shift_n, shift_d;
  logic signed [CW-1:0]  cnt_q, cnt1, cnt_n;
  xact_e                 st_q, st1, st_n, hdr_st;
  logic [HDR-1:0]        hdr;
  logic [AW-1:0]         phy_q, phy_n, reg_q, reg_n;
  logic [DW-1:0]         dsr_q, dsr_n, cdat_q, cdat_n;
  logic                  di_q, di_n, cv_q, cv_n, dec_pt;

  always_comb begin
    shift_n  = {shift_q[WIN-2:0], samp};
    sync_hit = rise && (&shift_n);
    cnt1     = sync_hit ? CW'(WIN) : cnt_q;
    hdr      = shift_n[HDR-1:0];
    hdr_st   = decode_hdr(hdr);
    dec_pt   = rise && (int'(cnt1) == HDR);
    st1      = dec_pt ? hdr_st : st_q;
    bank_addr = reg_of(hdr);

    shift_d = shift_q;
    cnt_n   = cnt_q;
    st_n    = st_q;
    phy_n   = phy_q;
    reg_n   = reg_q;
    dsr_n   = dsr_q;
    di_n    = di_q;
    cv_n    = 1'b0;
    cdat_n  = cdat_q;

    if (rise) begin
      shift_d = shift_n;
      cnt_n   = (int'(cnt1) < 0) ? cnt1 : cnt1 - CW'(1);
      st_n    = st1;
      if (dec_pt && hdr_st != ST_IDLE) begin
        phy_n = phy_of(hdr);
        reg_n = reg_of(hdr);
        if (hdr_st == ST_RD) dsr_n = bank_data;
      end
      if (int'(cnt1) < HDR && st1 == ST_RD) begin
        di_n  = dsr_n[DW-1];
        dsr_n = {dsr_n[DW-2:0], 1'b0};
      end
      if (int'(cnt1) == 0 && st1 != ST_IDLE) begin
        if (st1 == ST_WR) begin
          cv_n   = 1'b1;
          cdat_n = shift_n[DW-1:0];
        end
        st_n = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
      st_q    <= ST_IDLE;
      phy_q   <= '0;
      reg_q   <= '0;
      dsr_q   <= '0;
      di_q    <= 1'b0;
      cv_q    <= 1'b0;
      cdat_q  <= '0;
    end else begin
      shift_q <= shift_d;
      cnt_q   <= cnt_n;
      st_q    <= st_n;
      phy_q   <= phy_n;
      reg_q   <= reg_n;
      dsr_q   <= dsr_n;
      di_q    <= di_n;
      cv_q    <= cv_n;
      cdat_q  <= cdat_n;
    end
  end

  assign di          = di_q;
  assign commit_vld  = cv_q;
  assign commit_phy  = phy_q;
  assign commit_reg  = reg_q;
  assign commit_data = cdat_q;
  assign cnt_o       = cnt_q;
  assign st_o        = st_q;
endmodule

// File: rtl/mgmt_frame_responder.sv
module mgmt_frame_responder
  import mgmt_resp_pkg::*;
#(
  parameter int          WIN     = 32,
  parameter int          IDA_IDX = 2,
  parameter logic [15:0] IDA_VAL = 16'h0022,
  parameter int          IDB_IDX = 3,
  parameter logic [15:0] IDB_VAL = 16'h161A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic [CTL_W-1:0]  ctl_rdata,
  output logic              commit_vld,
  output logic [HDR_AW-1:0] commit_phy,
  output logic [HDR_AW-1:0] commit_reg,
  output logic [HDR_W-1:0]  commit_data
);
  localparam int NREG = 1 << HDR_AW;
  localparam int CW   = $clog2(WIN + 1) + 1;

  // named internal events, observed by the bound checker
  logic                 rise_evt, samp_bit, sync_evt, di_w;
  logic signed [CW-1:0] cnt_w;
  xact_e                st_w;
  logic [HDR_AW-1:0]    bank_addr;
  logic [HDR_W-1:0]     bank_data;

  mgmt_ctl_port u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ctl_we),
    .wdata (ctl_wdata),
    .di    (di_w),
    .rdata (ctl_rdata),
    .rise  (rise_evt),
    .samp  (samp_bit)
  );

  mgmt_reg_bank #(
    .NREG(NREG), .DW(HDR_W), .AW(HDR_AW),
    .IDA_IDX(IDA_IDX), .IDA_VAL(IDA_VAL),
    .IDB_IDX(IDB_IDX), .IDB_VAL(IDB_VAL)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (bank_addr),
    .rd_data (bank_data)
  );

  mgmt_frame_engine #(.WIN(WIN), .DW(HDR_W), .AW(HDR_AW), .CW(CW)) u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .rise        (rise_evt),
    .samp        (samp_bit),
    .bank_addr   (bank_addr),
    .bank_data   (bank_data),
    .di          (di_w),
    .commit_vld  (commit_vld),
    .commit_phy  (commit_phy),
    .commit_reg  (commit_reg),
    .commit_data (commit_data),
    .sync_hit    (sync_evt),
    .cnt_o       (cnt_w),
    .st_o        (st_w)
  );
endmodule

// File: rtl/mgmt_resp_chk.sv
module mgmt_resp_chk
  import mgmt_resp_pkg::*;
#(
  parameter int WIN = 32,
  parameter int CW  = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rise,
  input logic                 sync,
  input logic                 di,
  input logic                 commit_vld,
  input logic signed [CW-1:0] cnt,
  input xact_e                st
);
  p_di_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(di));

  p_cnt_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(cnt));

  p_sync_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> (int'(cnt) == WIN - 1));

  p_commit_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> !commit_vld);

  p_commit_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_vld |-> (st == ST_IDLE));

  p_read_armed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RD) |-> (int'(cnt) >= 0));
endmodule

bind mgmt_frame_responder mgmt_resp_chk #(.WIN(WIN), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rise       (rise_evt),
  .sync       (sync_evt),
  .di         (di_w),
  .commit_vld (commit_vld),
  .cnt        (cnt_w),
  .st         (st_w)
);

// File: tb/sim_mgmt_frame_responder.sv
`timescale 1ns/1ps
module sim_mgmt_frame_responder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [3:0]  ctl_wdata = '0;
  logic [3:0]  ctl_rdata;
  logic        commit_vld;
  logic [4:0]  commit_phy, commit_reg;
  logic [15:0] commit_data;

  int n_chk = 0;
  int n_err = 0;
  logic [15:0] cap;
  int          ncom;
  logic [4:0]  cphy, creg;
  logic [15:0] cdat;

  always #10 clk = ~clk;

  mgmt_frame_responder u0 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .commit_vld(commit_vld), .commit_phy(commit_phy),
    .commit_reg(commit_reg), .commit_data(commit_data)
  );

  // {is_write, phy, reg, write data, expected read data}
  localparam logic [42:0] VEC [8] = '{
    {1'b0, 5'd1,  5'd2,  16'h0000, 16'h0022},
    {1'b0, 5'd1,  5'd3,  16'h0000, 16'h161A},
    {1'b0, 5'd0,  5'd0,  16'h0000, 16'h0000},
    {1'b0, 5'd31, 5'd31, 16'h0000, 16'h0000},
    {1'b1, 5'd3,  5'd5,  16'hBEEF, 16'h0000},
    {1'b0, 5'd3,  5'd5,  16'h0000, 16'h0000},
    {1'b1, 5'd0,  5'd2,  16'hFFFF, 16'h0000},
    {1'b0, 5'd0,  5'd2,  16'h0000, 16'h0022}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] w);
    @(negedge clk);
    ctl_we = 1'b1;
    ctl_wdata = w;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  // bit layout: [3] clock, [2] drive enable, [1] returned data, [0] data
  task automatic mbit(input logic b, input logic oe);
    wr({1'b0, oe, 1'b0, b});
    wr({1'b1, oe, 1'b0, b});
    if (commit_vld) begin
      ncom++;
      cphy = commit_phy;
      creg = commit_reg;
      cdat = commit_data;
    end
  endtask

  task automatic run_frame(input int pre, input logic [1:0] st, input logic [1:0] op,
                           input logic [4:0] phy, input logic [4:0] rg,
                           input logic [1:0] ta, input logic ta_oe,
                           input logic [15:0] wd, input logic d_oe, input int pause_at);
    logic [13:0] hdr;
    ncom = 0;
    cap = '0;
    hdr = {st, op, phy, rg};
    repeat (pre) mbit(1'b1, 1'b1);
    for (int i = 13; i >= 0; i--) mbit(hdr[i], 1'b1);
    for (int i = 1; i >= 0; i--) mbit(ta[i], ta_oe);
    for (int i = 0; i < 16; i++) begin
      mbit(wd[15-i], d_oe);
      cap = {cap[14:0], ctl_rdata[1]};
      if (pause_at == i + 1) begin
        check("R6 mid-read bit", 32'(ctl_rdata[1]), 32'd1);
        wr(4'b1000);  // no clock rise, host tries to clear returned bit
        check("R10 returned bit held", 32'(ctl_rdata), 32'hA);
      end
    end
  endtask

  task automatic rd(input int pre, input logic [4:0] rg);
    run_frame(pre, 2'b01, 2'b10, 5'd1, rg, 2'b00, 1'b0, 16'h0, 1'b0, 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #4000000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 reset control word", 32'(ctl_rdata), 32'h0);
    check("R8 reset commit", 32'(commit_vld), 32'h0);

    // R10: host write of the returned-data bit is ignored
    wr(4'b0010);
    check("R10 write ignored", 32'(ctl_rdata), 32'h0);
    wr(4'b0101);
    check("R10 layout", 32'(ctl_rdata), 32'h5);

    // table walk: R4 R5 R6 R8 R9
    foreach (VEC[k]) begin
      if (VEC[k][42]) begin
        run_frame(32, 2'b01, 2'b01, VEC[k][41:37], VEC[k][36:32], 2'b10, 1'b1,
                  VEC[k][31:16], 1'b1, 0);
        check("R5 commit count", 32'(ncom), 32'd1);
        check("R5 commit phy", 32'(cphy), 32'(VEC[k][41:37]));
        check("R5 commit reg", 32'(creg), 32'(VEC[k][36:32]));
        check("R5 commit data", 32'(cdat), 32'(VEC[k][31:16]));
      end else begin
        run_frame(32, 2'b01, 2'b10, VEC[k][41:37], VEC[k][36:32], 2'b00, 1'b0,
                  16'h0, 1'b0, 0);
        check("R6 R8 R9 read data", 32'(cap), 32'(VEC[k][15:0]));
        check("R6 no commit on read", 32'(ncom), 32'd0);
      end
    end

    // R1 R10: non-rising write mid-read
    run_frame(32, 2'b01, 2'b10, 5'd1, 5'd3, 2'b00, 1'b0, 16'h0, 1'b0, 4);
    check("R1 read after pause", 32'(cap), 32'h161A);

    // R2: data high but drive-enable low must not synchronise
    repeat (32) mbit(1'b1, 1'b0);
    rd(0, 5'd3);
    check("R2 gated preamble", 32'(cap), 32'h0);

    // R7: invalid operation and start codes
    run_frame(32, 2'b01, 2'b11, 5'd1, 5'd3, 2'b00, 1'b0, 16'h0, 1'b0, 0);
    check("R7 bad op no data", 32'(cap), 32'h0);
    check("R7 bad op no commit", 32'(ncom), 32'd0);
    run_frame(32, 2'b00, 2'b01, 5'd1, 5'd4, 2'b10, 1'b1, 16'h1234, 1'b1, 0);
    check("R7 bad start no commit", 32'(ncom), 32'd0);

    // R6 R7: read with turnaround bit 0 set is rejected
    run_frame(32, 2'b01, 2'b10, 5'd1, 5'd3, 2'b01, 1'b1, 16'h0, 1'b0, 0);
    check("R6 turnaround reject", 32'(cap), 32'h0);

    // R5: write with wrong turnaround
    run_frame(32, 2'b01, 2'b01, 5'd1, 5'd4, 2'b00, 1'b1, 16'h5A5A, 1'b1, 0);
    check("R5 write turnaround reject", 32'(ncom), 32'd0);

    // R11: one-short preamble does not re-arm
    mbit(1'b0, 1'b1);
    rd(31, 5'd3);
    check("R11 short preamble", 32'(cap), 32'h0);

    // R3: long preamble still synchronises
    rd(45, 5'd3);
    check("R3 long preamble", 32'(cap), 32'h161A);

    // R8: reset mid-stream restores identifiers and clears the control word
    wr(4'b1101);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 control after reset", 32'(ctl_rdata), 32'h0);
    rd(32, 5'd2);
    check("R8 identifier after reset", 32'(cap), 32'h0022);

    finish_run();
  end
endmodule